// File: doc/BRIEF.md
# Serial page write receiver

This block accepts page-write transactions on a three-wire serial link (select, serial clock, data in) and stores the data into an internal byte-organised register array. The three serial inputs are brought into the system clock domain and their rising serial-clock edges are detected there. Each transaction carries a start bit, a two-bit opcode, an address and then any number of data units. The units collect in a page buffer, and the pointer into that buffer wraps inside a fixed-size page.

The buffered page goes into the array in a single cycle, and only after select is released. It is written only if the write-enable flag is high at that moment. A static mode input selects the unit size. In byte mode the address is 9 bits, units are 8 bits and a page holds 16 units. In word mode the address is 8 bits, units are 16 bits and a page holds 8 units. An asynchronous byte read port exposes the array contents.

Top module: `page_write_rx`

## Requirements
- R1: After reset every array byte reads 0xFF on `rd_data_o` (combinational read at `rd_addr_i`).
- R2: While select is high, `di_i` is sampled on each rising `sk_i` edge, MSB first. Zero bits before the first 1 are skipped. That 1 is the start bit, and the two bits after it are the opcode. Only opcode 01 (write) proceeds; opcodes 00, 10 and 11 leave the array unchanged.
- R3: In byte mode (`word_mode_i`=0), address A is 9 bits and units are 8 bits. Unit k lands at byte address {A[8:4], (A[3:0]+k) mod 16}.
- R4: In word mode (`word_mode_i`=1), word address W is 8 bits and units are 16 bits. Unit k lands at word {W[7:3], (W[2:0]+k) mod 8}. Word w occupies byte 2w (high half) and byte 2w+1 (low half).
- R5: The array does not change while select stays high. The buffered units are committed within 4 clock cycles after select falls.
- R6: A commit takes place only if `wen_i` is high when the select release is detected. If it is low, the array is unchanged.
- R7: A data unit that is incomplete when select falls is discarded. The complete units before it are still committed.
- R8: When more units arrive than a page holds, a later unit replaces the earlier buffered unit at the same wrapped position.
- R9: If select is released before the address is complete, the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Serial select, high during a transaction |
| sk_i | input | 1 | Serial clock; each level held at least 3 clk_i cycles |
| di_i | input | 1 | Serial data in |
| word_mode_i | input | 1 | 0: byte mode, 1: word mode; static during a transaction |
| wen_i | input | 1 | Write-enable flag |
| rd_addr_i | input | 9 | Array byte read address |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
The hardest situation to reach is a page that both wraps and overflows. Here the commit must show the last unit at each wrapped position and must leave the rest of the array untouched. The stimulus sweeps every start offset inside a page in both modes and sends one unit more than the page holds, so every offset sees wrap-around and an overwrite. After each transaction the whole array is compared with an arithmetic model. A second comparison is made just before select is released, which catches any write that happens too early.

// File: rtl/page_rx_pkg.sv
package page_rx_pkg;
  typedef enum logic [2:0] {
    PS_START,
    PS_OP,
    PS_ADDR,
    PS_DATA,
    PS_SKIP
  } prs_state_e;

  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/page_rx_sync.sv
module page_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic cs_fall_o,
  output logic sk_rise_o,
  output logic di_o
);
  logic [STAGES-1:0] cs_q, sk_q, di_q;
  logic cs_d, sk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= '0;
      sk_q <= '0;
      di_q <= '0;
      cs_d <= 1'b0;
      sk_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[STAGES-2:0], cs_i};
      sk_q <= {sk_q[STAGES-2:0], sk_i};
      di_q <= {di_q[STAGES-2:0], di_i};
      cs_d <= cs_q[STAGES-1];
      sk_d <= sk_q[STAGES-1];
    end
  end

  assign cs_o      = cs_q[STAGES-1];
  assign di_o      = di_q[STAGES-1];
  assign sk_rise_o = sk_q[STAGES-1] & ~sk_d;
  assign cs_fall_o = cs_d & ~cs_q[STAGES-1];
endmodule

// File: rtl/page_rx_parser.sv
module page_rx_parser
  import page_rx_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int UNIT_W  = 8,
  parameter int PAGE_LG = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_i,
  input  logic                      bit_stb_i,
  input  logic                      bit_i,
  input  logic                      word_mode_i,
  output logic                      unit_wr_o,
  output logic [PAGE_LG-1:0]        unit_idx_o,
  output logic [2*UNIT_W-1:0]       unit_data_o,
  output logic [ADDR_W-PAGE_LG-1:0] page_o,
  output logic                      in_data_o
);
  localparam int DW = 2 * UNIT_W;
  localparam int CW = $clog2(DW + 1);

  prs_state_e        state_q;
  logic [CW-1:0]     cnt_q, addr_last, unit_last;
  logic [DW-1:0]     sh_q, sh_nxt;
  logic [ADDR_W-1:0] ptr_q, ptr_load, ptr_adv;
  logic [PAGE_LG-1:0] step;
  logic              unit_done;

  assign sh_nxt    = {sh_q[DW-2:0], bit_i};
  assign addr_last = word_mode_i ? CW'(ADDR_W - 2) : CW'(ADDR_W - 1);
  assign unit_last = word_mode_i ? CW'(DW - 1) : CW'(UNIT_W - 1);
  assign step      = word_mode_i ? PAGE_LG'(2) : PAGE_LG'(1);
  // word addresses become even byte pointers
  assign ptr_load  = word_mode_i ? {sh_nxt[ADDR_W-2:0], 1'b0} : sh_nxt[ADDR_W-1:0];
  assign ptr_adv   = {ptr_q[ADDR_W-1:PAGE_LG], ptr_q[PAGE_LG-1:0] + step};
  assign unit_done = cs_i && bit_stb_i && (state_q == PS_DATA) && (cnt_q == unit_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_START;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
    end else if (!cs_i) begin
      state_q <= PS_START;
      cnt_q   <= '0;
    end else if (bit_stb_i) begin
      unique case (state_q)
        PS_START: begin
          if (bit_i) begin
            state_q <= PS_OP;
            cnt_q   <= '0;
          end
        end
        PS_OP: begin
          sh_q <= sh_nxt;
          if (cnt_q == CW'(1)) begin
            cnt_q   <= '0;
            state_q <= (sh_nxt[1:0] == OP_WRITE) ? PS_ADDR : PS_SKIP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PS_ADDR: begin
          sh_q <= sh_nxt;
          if (cnt_q == addr_last) begin
            cnt_q   <= '0;
            ptr_q   <= ptr_load;
            state_q <= PS_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PS_DATA: begin
          sh_q <= sh_nxt;
          if (cnt_q == unit_last) begin
            cnt_q <= '0;
            ptr_q <= ptr_adv;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign unit_wr_o   = unit_done;
  assign unit_idx_o  = ptr_q[PAGE_LG-1:0];
  assign unit_data_o = word_mode_i ? sh_nxt : {{UNIT_W{1'b0}}, sh_nxt[UNIT_W-1:0]};
  assign page_o      = ptr_q[ADDR_W-1:PAGE_LG];
  assign in_data_o   = (state_q == PS_DATA);
endmodule

// File: rtl/page_rx_buffer.sv
module page_rx_buffer #(
  parameter int UNIT_W  = 8,
  parameter int PAGE_LG = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic                           word_i,
  input  logic [PAGE_LG-1:0]             idx_i,
  input  logic [2*UNIT_W-1:0]            data_i,
  input  logic                           clr_i,
  output logic [(1<<PAGE_LG)-1:0][UNIT_W-1:0] ent_o,
  output logic [(1<<PAGE_LG)-1:0]        vld_o
);
  localparam int NENT = 1 << PAGE_LG;

  logic [PAGE_LG-1:0] idx_odd;
  assign idx_odd = {idx_i[PAGE_LG-1:1], 1'b1};

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic sel_b, sel_hi, sel_lo;
    assign sel_b  = wr_i && !word_i && (idx_i == PAGE_LG'(e));
    assign sel_hi = wr_i && word_i && (idx_i == PAGE_LG'(e));
    assign sel_lo = wr_i && word_i && (idx_odd == PAGE_LG'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_o[e] <= '0;
        vld_o[e] <= 1'b0;
      end else if (clr_i) begin
        vld_o[e] <= 1'b0;
      end else if (sel_b || sel_lo) begin
        ent_o[e] <= data_i[UNIT_W-1:0];
        vld_o[e] <= 1'b1;
      end else if (sel_hi) begin
        ent_o[e] <= data_i[2*UNIT_W-1:UNIT_W];
        vld_o[e] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/page_rx_array.sv
module page_rx_array #(
  parameter int ADDR_W  = 9,
  parameter int UNIT_W  = 8,
  parameter int PAGE_LG = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           commit_i,
  input  logic [ADDR_W-PAGE_LG-1:0]      page_i,
  input  logic [(1<<PAGE_LG)-1:0][UNIT_W-1:0] ent_i,
  input  logic [(1<<PAGE_LG)-1:0]        vld_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  output logic [UNIT_W-1:0]              rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NENT  = 1 << PAGE_LG;

  logic [UNIT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '1;
    end else if (commit_i) begin
      for (int e = 0; e < NENT; e++) begin
        if (vld_i[e]) mem_q[{page_i, PAGE_LG'(e)}] <= ent_i[e];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/page_write_rx.sv
module page_write_rx #(
  parameter int ADDR_W      = 9,
  parameter int UNIT_W      = 8,
  parameter int PAGE_LG     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              word_mode_i,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [UNIT_W-1:0] rd_data_o
);
  localparam int NENT = 1 << PAGE_LG;
  localparam int PG_W = ADDR_W - PAGE_LG;

  logic cs_s, cs_fall, sk_rise, di_s;
  logic unit_wr, in_data, commit;
  logic [PAGE_LG-1:0]  unit_idx;
  logic [2*UNIT_W-1:0] unit_data;
  logic [PG_W-1:0]     page;
  logic [NENT-1:0][UNIT_W-1:0] ent;
  logic [NENT-1:0]     vld;

  page_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_i, .sk_i, .di_i,
    .cs_o(cs_s), .cs_fall_o(cs_fall), .sk_rise_o(sk_rise), .di_o(di_s)
  );

  page_rx_parser #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .PAGE_LG(PAGE_LG)) u_parser (
    .clk_i, .rst_ni, .cs_i(cs_s), .bit_stb_i(sk_rise), .bit_i(di_s),
    .word_mode_i, .unit_wr_o(unit_wr), .unit_idx_o(unit_idx),
    .unit_data_o(unit_data), .page_o(page), .in_data_o(in_data)
  );

  page_rx_buffer #(.UNIT_W(UNIT_W), .PAGE_LG(PAGE_LG)) u_buf (
    .clk_i, .rst_ni, .wr_i(unit_wr), .word_i(word_mode_i), .idx_i(unit_idx),
    .data_i(unit_data), .clr_i(cs_fall), .ent_o(ent), .vld_o(vld)
  );

  // release of select while in the data phase commits the page
  assign commit = cs_fall && in_data && wen_i;

  page_rx_array #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .PAGE_LG(PAGE_LG)) u_array (
    .clk_i, .rst_ni, .commit_i(commit), .page_i(page), .ent_i(ent), .vld_i(vld),
    .rd_addr_i, .rd_data_o
  );
endmodule

// File: rtl/page_write_rx_chk.sv
module page_write_rx_chk #(
  parameter int ADDR_W  = 9,
  parameter int UNIT_W  = 8,
  parameter int PAGE_LG = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cs_s,
  input logic                      commit,
  input logic                      wen_i,
  input logic                      unit_wr,
  input logic                      in_data,
  input logic                      word_mode_i,
  input logic [PAGE_LG-1:0]        unit_idx,
  input logic [ADDR_W-PAGE_LG-1:0] page,
  input logic [ADDR_W-1:0]         rd_addr_i,
  input logic [UNIT_W-1:0]         rd_data_o
);
  // R6
  commit_needs_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> wen_i);

  // R5
  commit_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (!cs_s && $past(cs_s)));

  // R5
  array_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_addr_i == $past(rd_addr_i)) && !$past(commit)) |-> $stable(rd_data_o));

  // R3
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data && $past(in_data) && cs_s && $past(cs_s)) |-> $stable(page));

  // R4
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_wr && word_mode_i) |-> !unit_idx[0]);

  // R2
  unit_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_wr |-> (in_data && cs_s));
endmodule

bind page_write_rx page_write_rx_chk #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .PAGE_LG(PAGE_LG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .commit(commit), .wen_i(wen_i),
  .unit_wr(unit_wr), .in_data(in_data), .word_mode_i(word_mode_i),
  .unit_idx(unit_idx), .page(page), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
);

// File: tb/page_write_rx_test.sv
module page_write_rx_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 1'b0, sk_i = 1'b0, di_i = 1'b0;
  logic word_mode_i = 1'b0, wen_i = 1'b0;
  logic [8:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [512];

  always #4 clk = ~clk;

  page_write_rx uut (
    .clk_i(clk), .rst_ni, .cs_i, .sk_i, .di_i, .word_mode_i, .wen_i,
    .rd_addr_i, .rd_data_o
  );

  function automatic logic [15:0] unit_val(int seed, int k);
    return 16'(seed * 40503 + k * 2659 + 17);
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    di_i = b;
    sk_i = 1'b0;
    repeat (3) @(negedge clk);
    sk_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_all(input string tag);
    for (int a = 0; a < 512; a++) begin
      rd_addr_i = 9'(a);
      #1;
      vecs++;
      if (rd_data_o !== ref_mem[a]) begin
        fails++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rd_data_o, ref_mem[a]);
      end
    end
  endtask

  task automatic xfer(input bit wm, input int addr, input int nunits, input int seed,
                      input int extra, input logic [1:0] op, input bit wen,
                      input int lead, input string tag);
    int alen, uw;
    logic [15:0] d;
    alen = wm ? 8 : 9;
    uw   = wm ? 16 : 8;
    word_mode_i = wm;
    wen_i = wen;
    sk_i = 1'b0;
    @(negedge clk);
    cs_i = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < lead; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_bit(op[1]);
    send_bit(op[0]);
    for (int i = alen - 1; i >= 0; i--) send_bit(1'((addr >> i) & 1));
    for (int k = 0; k < nunits; k++) begin
      d = unit_val(seed, k);
      for (int i = uw - 1; i >= 0; i--) send_bit(d[i]);
    end
    for (int i = 0; i < extra; i++) send_bit(1'(i & 1));
    repeat (10) @(negedge clk);
    chk_all("R5 before release");
    cs_i = 1'b0;
    sk_i = 1'b0;
    repeat (10) @(negedge clk);
    if (op == 2'b01 && wen) begin
      for (int k = 0; k < nunits; k++) begin
        d = unit_val(seed, k);
        if (!wm) begin
          ref_mem[(addr & ~15) | ((addr + k) & 15)] = d[7:0];
        end else begin
          int w;
          w = (addr & ~7) | ((addr + k) & 7);
          ref_mem[2*w]   = d[15:8];
          ref_mem[2*w+1] = d[7:0];
        end
      end
    end
    chk_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 512; a++) ref_mem[a] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset contents
    chk_all("R1 reset");
    // R3 basic byte page write
    xfer(1'b0, 'h0A5, 3, 1, 0, 2'b01, 1'b1, 0, "R3 byte");
    // R3 wrap inside page
    xfer(1'b0, 'h13E, 5, 2, 0, 2'b01, 1'b1, 0, "R3 byte wrap");
    // R8 overflow overwrites wrapped entries
    xfer(1'b0, 'h040, 20, 3, 0, 2'b01, 1'b1, 0, "R8 byte overflow");
    // R4 word mode
    xfer(1'b1, 'h21, 3, 4, 0, 2'b01, 1'b1, 0, "R4 word");
    // R4/R8 word wrap and overflow
    xfer(1'b1, 'h7E, 11, 5, 0, 2'b01, 1'b1, 0, "R8 word overflow");
    // R7 partial unit dropped
    xfer(1'b0, 'h1F3, 2, 6, 5, 2'b01, 1'b1, 0, "R7 byte partial");
    xfer(1'b1, 'hC4, 1, 7, 9, 2'b01, 1'b1, 0, "R7 word partial");
    // R6 write enable low
    xfer(1'b0, 'h0A5, 4, 8, 0, 2'b01, 1'b0, 0, "R6 wen low");
    // R2 non-write opcodes
    xfer(1'b0, 'h0A5, 2, 9, 0, 2'b10, 1'b1, 0, "R2 opcode 10");
    xfer(1'b0, 'h0A5, 2, 9, 0, 2'b11, 1'b1, 0, "R2 opcode 11");
    xfer(1'b1, 'h52, 2, 9, 0, 2'b00, 1'b1, 0, "R2 opcode 00");
    // R2 leading zeros skipped
    xfer(1'b0, 'h0C0, 2, 10, 0, 2'b01, 1'b1, 3, "R2 leading zeros");
    // R9 release during address
    begin
      word_mode_i = 1'b0;
      wen_i = 1'b1;
      @(negedge clk);
      cs_i = 1'b1;
      repeat (4) @(negedge clk);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      for (int i = 0; i < 5; i++) send_bit(1'(i & 1));
      cs_i = 1'b0;
      sk_i = 1'b0;
      repeat (10) @(negedge clk);
      chk_all("R9 early release");
    end
    // R3/R8 sweep of start offsets, byte mode, one unit past a page
    for (int off = 0; off < 16; off++)
      xfer(1'b0, (off * 2 + 1) * 16 + off, 17, 20 + off, 0, 2'b01, 1'b1, 0, "R3 byte sweep");
    // R4/R8 sweep of start offsets, word mode
    for (int off = 0; off < 8; off++)
      xfer(1'b1, (off * 3 + 2) * 8 + off, 9, 40 + off, 0, 2'b01, 1'b1, 0, "R4 word sweep");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule